// File: doc/BRIEF.md
# I2C Byte-Level Master Controller

This block is the master side of a two-wire serial bus, run one operation at a time by software through a small command interface. Each accepted command is one of: a Start condition, a Repeated Start, a Stop condition, a byte write or a byte read. The block drives the serial clock and data lines as open-drain outputs. An output-enable high pulls the line low, and a low output-enable releases it, so the line reads high through the pull-up. When an operation finishes, the block raises an interrupt flag.

Software builds the whole transfer from these operations. A typical write is Start, then the address byte with its direction bit (a 7-bit slave address in the upper bits and a 0 in bit 0 to write, or a 1 to read), then data bytes, then Stop. Software may issue a Repeated Start in place of the Stop. That begins the next transfer without releasing the bus. After a write, the slave's acknowledge is held in a status output. After a read, the received byte is held in a data output. The acknowledge that the master sends back after a read is chosen with each read command.

Bit timing comes from a tick input supplied by an external baud-rate counter. Every bit and every bus condition lasts four tick intervals. With a tick rate of four times 100 kHz, 400 kHz or 1 MHz, the bus runs at that rate. Clock stretching, arbitration between masters, slave operation and 10-bit addressing are not handled.

Top module: `i2c_byte_master`

## Requirements
- R1: A command is accepted when `cmd_valid` is high, `busy` is low and `cmd_op` is one of the codes 1 (Start), 2 (Repeated Start), 3 (Stop), 4 (Write byte) or 5 (Read byte). Codes 0, 6 and 7 are ignored and start nothing. `busy` is high from the cycle after acceptance until the cycle in which `irq` sets.
- R2: A Start begins with both lines released. SDA then falls while SCL is high, and SCL then falls. A Repeated Start begins with SCL low: it releases SDA, releases SCL, pulls SDA low while SCL is high, and pulls SCL low, with no Stop in between. Both end with both lines low.
- R3: A Stop pulls SDA low while SCL is low, releases SCL, and then releases SDA while SCL is high. It ends with both lines released.
- R4: A Write shifts out `cmd_wdata` on eight SCL pulses, most significant bit first. During a Write or a Read, SDA changes only while SCL is low.
- R5: On the ninth SCL pulse of a Write, the master releases SDA and latches the sampled level into `ack_status` (0 = slave acknowledged, 1 = not acknowledged).
- R6: A Read samples SDA on eight SCL pulses, most significant bit first. The byte appears on `rx_data` when the operation completes.
- R7: On the ninth SCL pulse of a Read, the master drives SDA with the `cmd_nack` value given with the command (0 pulls SDA low to acknowledge, 1 releases it).
- R8: `irq` sets when each operation completes and stays set until `irq_clr` is pulsed. A completion in the same cycle as `irq_clr` wins.
- R9: Each bit and each condition takes four `tick` intervals, so the SCL period during a byte is four tick intervals. Phase state advances only on `tick`.
- R10: A command presented while `busy` is high is ignored. The byte in progress is not altered, and no further operation follows it.
- R11: After reset, both lines are released, and `busy`, `irq`, `ack_status` and `rx_data` are zero.
- R12: Between operations both lines hold the level that the last operation left them at.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Quarter-bit timing strobe from the baud-rate counter |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 3 | Operation code: 1 Start, 2 Repeated Start, 3 Stop, 4 Write, 5 Read |
| cmd_wdata | input | 8 | Byte to send on Write |
| cmd_nack | input | 1 | Acknowledge bit the master sends after a Read (1 = not acknowledge) |
| irq_clr | input | 1 | Clears the completion flag |
| sda_in | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pulls SCL low when high |
| sda_oe | output | 1 | Pulls SDA low when high |
| busy | output | 1 | Operation in progress |
| irq | output | 1 | Completion flag |
| ack_status | output | 1 | Slave acknowledge from the last Write (1 = not acknowledged) |
| rx_data | output | 8 | Byte from the last Read |

## Verification
The bench plays a slave on the wired-AND lines. It counts SDA edges during SCL high, to check Start, Repeated Start and Stop, and it watches for any SDA change under a high SCL inside a byte. A controller that changed data on the wrong quarter would create spurious Start or Stop conditions. A controller that mixed up bit order or the ninth-bit direction would corrupt the captured byte, the latched acknowledge or the master's acknowledge. The bench also sends a Write while another Write is running and sends an illegal code. A design that did not block these would disturb the byte on the bus or produce SCL pulses afterwards. It measures the SCL period against the tick interval and checks that the completion flag survives until it is cleared.

// File: rtl/i2c_bm_pkg.sv
package i2c_bm_pkg;

  typedef enum logic [2:0] {
    OP_IDLE    = 3'd0,
    OP_START   = 3'd1,
    OP_RESTART = 3'd2,
    OP_STOP    = 3'd3,
    OP_WRITE   = 3'd4,
    OP_READ    = 3'd5
  } op_e;

  localparam logic [1:0] Q_LEAD   = 2'd0;
  localparam logic [1:0] Q_RISE   = 2'd1;
  localparam logic [1:0] Q_SAMPLE = 2'd2;
  localparam logic [1:0] Q_TRAIL  = 2'd3;

  function automatic logic op_legal(input logic [2:0] code);
    return (code >= 3'd1) && (code <= 3'd5);
  endfunction

  function automatic logic op_is_byte(input op_e op);
    return (op == OP_WRITE) || (op == OP_READ);
  endfunction

endpackage

// File: rtl/i2c_bm_rst_sync.sv
module i2c_bm_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/i2c_bm_quarter_timer.sv
module i2c_bm_quarter_timer
  import i2c_bm_pkg::*;
#(
  parameter int BW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          run,
  input  logic          tick,
  input  logic [BW-1:0] last_bit,
  output logic [1:0]    quarter,
  output logic [BW-1:0] bit_idx,
  output logic          sample_stb,
  output logic          adv_stb,
  output logic          done_stb
);

  logic [1:0]    q_q, q_d;
  logic [BW-1:0] b_q, b_d;
  logic          step;

  assign step       = run && tick;
  assign adv_stb    = step && (q_q == Q_TRAIL);
  assign done_stb   = adv_stb && (b_q == last_bit);
  assign sample_stb = step && (q_q == Q_SAMPLE);

  always_comb begin
    q_d = q_q;
    b_d = b_q;
    if (clr) begin
      q_d = Q_LEAD;
      b_d = '0;
    end else if (step) begin
      if (q_q == Q_TRAIL) begin
        q_d = Q_LEAD;
        b_d = (b_q == last_bit) ? '0 : b_q + 1'b1;
      end else begin
        q_d = q_q + 2'd1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_q <= Q_LEAD;
      b_q <= '0;
    end else begin
      q_q <= q_d;
      b_q <= b_d;
    end
  end

  assign quarter = q_q;
  assign bit_idx = b_q;

  // R9: the phase moves only on a tick
  p_quarter_waits_tick_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(q_q));

  // R9: the bit index never passes the last bit of the operation
  p_bit_in_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> (b_q <= last_bit));

endmodule

// File: rtl/i2c_bm_shifter.sv
module i2c_bm_shifter #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         shift_en,
  input  logic         bit_in,
  output logic [W-1:0] data
);

  logic [W-1:0] sh_q, sh_d;

  always_comb begin
    sh_d = sh_q;
    if (load) begin
      sh_d = load_val;
    end else if (shift_en) begin
      sh_d = {sh_q[W-2:0], bit_in};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0;
    end else begin
      sh_q <= sh_d;
    end
  end

  assign data = sh_q;

endmodule

// File: rtl/i2c_byte_master.sv
module i2c_byte_master
  import i2c_bm_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              cmd_valid,
  input  logic [2:0]        cmd_op,
  input  logic [DATA_W-1:0] cmd_wdata,
  input  logic              cmd_nack,
  input  logic              irq_clr,
  input  logic              sda_in,
  output logic              scl_oe,
  output logic              sda_oe,
  output logic              busy,
  output logic              irq,
  output logic              ack_status,
  output logic [DATA_W-1:0] rx_data
);

  localparam int             BW      = $clog2(DATA_W + 1);
  localparam logic [BW-1:0]  ACK_IDX = BW'(DATA_W);

  logic              rst_q_n;
  op_e               op_q, op_d;
  logic              busy_q, busy_d;
  logic              irq_q, irq_d;
  logic              ack_q, ack_d;
  logic              mack_q, mack_d;
  logic [DATA_W-1:0] rx_q, rx_d;
  logic              scl_q, scl_d;
  logic              sda_q, sda_d;
  logic              scl_lvl, sda_lvl;

  logic              accept;
  logic [1:0]        quarter;
  logic [BW-1:0]     bit_idx;
  logic [BW-1:0]     last_bit;
  logic              sample_stb, adv_stb, done_stb;
  logic              at_ack;
  logic              scl_high_q;
  logic [DATA_W-1:0] sh_data;
  logic [DATA_W-1:0] sh_ld_val;
  logic              sh_en;

  i2c_bm_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_q_n)
  );

  assign accept   = cmd_valid && !busy_q && op_legal(cmd_op);
  assign last_bit = op_is_byte(op_q) ? ACK_IDX : '0;
  assign at_ack   = (bit_idx == ACK_IDX);

  i2c_bm_quarter_timer #(.BW(BW)) u_timer (
    .clk        (clk),
    .rst_n      (rst_q_n),
    .clr        (accept),
    .run        (busy_q),
    .tick       (tick),
    .last_bit   (last_bit),
    .quarter    (quarter),
    .bit_idx    (bit_idx),
    .sample_stb (sample_stb),
    .adv_stb    (adv_stb),
    .done_stb   (done_stb)
  );

  assign sh_ld_val = (cmd_op == OP_WRITE) ? cmd_wdata : '0;
  assign sh_en     = busy_q && !at_ack &&
                     (((op_q == OP_READ) && sample_stb) ||
                      ((op_q == OP_WRITE) && adv_stb));

  i2c_bm_shifter #(.W(DATA_W)) u_shifter (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .load     (accept),
    .load_val (sh_ld_val),
    .shift_en (sh_en),
    .bit_in   (sda_in),
    .data     (sh_data)
  );

  // SCL is high in the middle two quarters of a data bit
  assign scl_high_q = (quarter == Q_RISE) || (quarter == Q_SAMPLE);

  // waveform decode: line levels per operation and quarter
  always_comb begin
    scl_lvl = scl_q;
    sda_lvl = sda_q;
    case (op_q)
      OP_START: begin
        scl_lvl = (quarter != Q_TRAIL);
        sda_lvl = (quarter == Q_LEAD);
      end
      OP_RESTART: begin
        scl_lvl = scl_high_q;
        sda_lvl = (quarter == Q_LEAD) || (quarter == Q_RISE);
      end
      OP_STOP: begin
        scl_lvl = (quarter != Q_LEAD);
        sda_lvl = (quarter == Q_SAMPLE) || (quarter == Q_TRAIL);
      end
      OP_WRITE: begin
        scl_lvl = scl_high_q;
        sda_lvl = at_ack ? 1'b1 : sh_data[DATA_W-1];
      end
      OP_READ: begin
        scl_lvl = scl_high_q;
        sda_lvl = at_ack ? mack_q : 1'b1;
      end
      default: begin
        scl_lvl = scl_q;
        sda_lvl = sda_q;
      end
    endcase
  end

  // next-state logic
  always_comb begin
    op_d   = op_q;
    busy_d = busy_q;
    irq_d  = irq_q;
    ack_d  = ack_q;
    mack_d = mack_q;
    rx_d   = rx_q;
    scl_d  = scl_q;
    sda_d  = sda_q;

    if (accept) begin
      op_d   = op_e'(cmd_op);
      busy_d = 1'b1;
      mack_d = cmd_nack;
    end

    if (busy_q) begin
      scl_d = scl_lvl;
      sda_d = sda_lvl;
    end

    if (busy_q && (op_q == OP_WRITE) && at_ack && sample_stb) begin
      ack_d = sda_in;
    end

    if (irq_clr) begin
      irq_d = 1'b0;
    end

    if (done_stb) begin
      busy_d = 1'b0;
      irq_d  = 1'b1;
      if (op_q == OP_READ) begin
        rx_d = sh_data;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      op_q   <= OP_IDLE;
      busy_q <= 1'b0;
      irq_q  <= 1'b0;
      ack_q  <= 1'b0;
      mack_q <= 1'b0;
      rx_q   <= '0;
      scl_q  <= 1'b1;
      sda_q  <= 1'b1;
    end else begin
      op_q   <= op_d;
      busy_q <= busy_d;
      irq_q  <= irq_d;
      ack_q  <= ack_d;
      mack_q <= mack_d;
      rx_q   <= rx_d;
      scl_q  <= scl_d;
      sda_q  <= sda_d;
    end
  end

  assign scl_oe     = ~scl_q;
  assign sda_oe     = ~sda_q;
  assign busy       = busy_q;
  assign irq        = irq_q;
  assign ack_status = ack_q;
  assign rx_data    = rx_q;

  // R1: busy ends only together with a raised completion flag
  p_busy_ends_with_irq_r1: assert property (@(posedge clk) disable iff (!rst_q_n)
    $fell(busy_q) |-> irq_q);

  // R10: a command during an operation leaves the operation unchanged
  p_ignore_when_busy_r10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_q && cmd_valid) |=> (op_q == $past(op_q)));

  // R4: inside a byte, SDA holds while SCL stays high
  p_sda_still_scl_high_r4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (busy_q && $past(busy_q) && op_is_byte(op_q) && scl_q && $past(scl_q))
      |-> (sda_q == $past(sda_q)));

  // R12: lines hold their level while no operation runs
  p_lines_hold_idle_r12: assert property (@(posedge clk) disable iff (!rst_q_n)
    !busy_q |=> ($stable(scl_q) && $stable(sda_q)));

endmodule

// File: tb/i2c_byte_master_bench.sv
module i2c_byte_master_bench;

  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 5;
  localparam int NVEC       = 8;

  // vector: {op[2:0], data[7:0], slave_nack, master_nack}
  localparam logic [12:0] VEC [NVEC] = '{
    {3'd1, 8'h00, 1'b0, 1'b0},
    {3'd4, 8'hA4, 1'b0, 1'b0},
    {3'd4, 8'h3C, 1'b1, 1'b0},
    {3'd2, 8'h00, 1'b0, 1'b0},
    {3'd4, 8'hA5, 1'b0, 1'b0},
    {3'd5, 8'h96, 1'b0, 1'b0},
    {3'd5, 8'h0F, 1'b0, 1'b1},
    {3'd3, 8'h00, 1'b0, 1'b0}
  };

  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick = 1'b0;
  logic       cmd_valid, cmd_nack, irq_clr;
  logic [2:0] cmd_op;
  logic [7:0] cmd_wdata;
  logic       scl_oe, sda_oe, busy, irq, ack_status;
  logic [7:0] rx_data;
  logic       slave_pull;
  logic       scl_line, sda_line;

  int checks = 0;
  int fails  = 0;
  int tcnt   = 0;
  int starts = 0;
  int stops  = 0;
  int bad_chg = 0;
  int scl_rises = 0;
  logic in_byte = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign scl_line = ~scl_oe;
  assign sda_line = ~(sda_oe | slave_pull);

  i2c_byte_master u_i2c_byte_master (
    .clk        (clk),
    .rst_n      (rst_n),
    .tick       (tick),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .cmd_wdata  (cmd_wdata),
    .cmd_nack   (cmd_nack),
    .irq_clr    (irq_clr),
    .sda_in     (sda_line),
    .scl_oe     (scl_oe),
    .sda_oe     (sda_oe),
    .busy       (busy),
    .irq        (irq),
    .ack_status (ack_status),
    .rx_data    (rx_data)
  );

  always @(posedge clk) begin
    if (tcnt == TICK_DIV - 1) begin
      tcnt <= 0;
      tick <= 1'b1;
    end else begin
      tcnt <= tcnt + 1;
      tick <= 1'b0;
    end
  end

  always @(negedge sda_line) if (scl_line === 1'b1) starts++;
  always @(posedge sda_line) if (scl_line === 1'b1) stops++;
  always @(sda_line) if (in_byte && scl_line === 1'b1) bad_chg++;
  always @(posedge scl_line) scl_rises++;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] op, input logic [7:0] d, input logic nk);
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = op;
    cmd_wdata = d;
    cmd_nack  = nk;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b1, "R1", "busy after accept", int'(busy), 1);
  endtask

  task automatic wait_irq();
    while (irq !== 1'b1) @(negedge clk);
    chk(busy === 1'b0, "R1", "busy low with irq", int'(busy), 0);
  endtask

  task automatic clr_irq();
    chk(irq === 1'b1, "R8", "irq held before clear", int'(irq), 1);
    @(negedge clk);
    irq_clr = 1'b1;
    @(negedge clk);
    irq_clr = 1'b0;
    chk(irq === 1'b0, "R8", "irq cleared", int'(irq), 0);
  endtask

  task automatic do_cond(input logic [2:0] op);
    int s0 = starts;
    int p0 = stops;
    issue(op, 8'h00, 1'b0);
    wait_irq();
    repeat (3) @(negedge clk);
    if (op == 3'd3) begin
      chk(stops == p0 + 1, "R3", "stop seen", stops, p0 + 1);
      chk(scl_line === 1'b1 && sda_line === 1'b1, "R3", "lines released",
          int'({scl_line, sda_line}), 3);
    end else begin
      chk(starts == s0 + 1, "R2", "start seen", starts, s0 + 1);
      chk(stops == p0, "R2", "no stop in start", stops, p0);
      chk(scl_line === 1'b0 && sda_line === 1'b0, "R2", "lines low",
          int'({scl_line, sda_line}), 0);
    end
    clr_irq();
  endtask

  task automatic do_write(input logic [7:0] d, input logic sn, input bit inject);
    logic [7:0] cap;
    time t0;
    in_byte = 1'b1;
    issue(3'd4, d, 1'b0);
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_line);
      if (i == 0) t0 = $time;
      if (i == 1) chk(($time - t0) == 4 * TICK_DIV * CLK_PERIOD, "R9",
                      "scl period", int'($time - t0), 4 * TICK_DIV * CLK_PERIOD);
      cap[7-i] = sda_line;
      if (inject && i == 2) begin
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_op    = 3'd4;
        cmd_wdata = 8'h11;
        @(negedge clk);
        cmd_valid = 1'b0;
      end
      @(negedge scl_line);
    end
    slave_pull = !sn;
    @(posedge scl_line);
    @(negedge scl_line);
    slave_pull = 1'b0;
    wait_irq();
    in_byte = 1'b0;
    chk(cap == d, inject ? "R10" : "R4", "byte on wire", int'(cap), int'(d));
    chk(ack_status === sn, "R5", "ack status", int'(ack_status), int'(sn));
    chk(scl_line === 1'b0, "R12", "scl low after byte", int'(scl_line), 0);
    clr_irq();
  endtask

  task automatic do_read(input logic [7:0] d, input logic mk);
    logic m;
    in_byte = 1'b1;
    slave_pull = ~d[7];
    issue(3'd5, 8'h00, mk);
    for (int i = 0; i < 8; i++) begin
      @(posedge scl_line);
      @(negedge scl_line);
      slave_pull = (i < 7) ? ~d[6-i] : 1'b0;
    end
    @(posedge scl_line);
    m = sda_line;
    @(negedge scl_line);
    wait_irq();
    in_byte = 1'b0;
    chk(rx_data == d, "R6", "received byte", int'(rx_data), int'(d));
    chk(m === mk, "R7", "master ack bit", int'(m), int'(mk));
    clr_irq();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=%0d expected=%0d cycles", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int r0;
    rst_n      = 1'b0;
    cmd_valid  = 1'b0;
    cmd_op     = 3'd0;
    cmd_wdata  = 8'h00;
    cmd_nack   = 1'b0;
    irq_clr    = 1'b0;
    slave_pull = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11: reset state
    chk(busy === 1'b0, "R11", "busy", int'(busy), 0);
    chk(irq === 1'b0, "R11", "irq", int'(irq), 0);
    chk(scl_oe === 1'b0 && sda_oe === 1'b0, "R11", "lines released",
        int'({scl_oe, sda_oe}), 0);
    chk(ack_status === 1'b0, "R11", "ack_status", int'(ack_status), 0);
    chk(rx_data === 8'h00, "R11", "rx_data", int'(rx_data), 0);

    // R1: illegal code ignored
    r0 = scl_rises;
    @(negedge clk);
    cmd_valid = 1'b1;
    cmd_op    = 3'd6;
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(busy === 1'b0, "R1", "illegal op not accepted", int'(busy), 0);
    repeat (30) @(negedge clk);
    chk(scl_oe === 1'b0 && scl_rises == r0, "R1", "no bus activity",
        scl_rises, r0);

    // table of operations
    for (int k = 0; k < NVEC; k++) begin
      logic [12:0] v;
      v = VEC[k];
      case (v[12:10])
        3'd1, 3'd2, 3'd3: do_cond(v[12:10]);
        3'd4:             do_write(v[9:2], v[1], 1'b0);
        3'd5:             do_read(v[9:2], v[0]);
        default:          ;
      endcase
    end
    chk(bad_chg == 0, "R4", "sda changes under high scl", bad_chg, 0);

    // R10: command during a byte is ignored
    do_cond(3'd1);
    do_write(8'h5A, 1'b0, 1'b1);
    r0 = scl_rises;
    repeat (60) @(negedge clk);
    chk(scl_rises == r0, "R10", "no follow-on operation", scl_rises, r0);
    chk(busy === 1'b0, "R10", "idle after ignored command", int'(busy), 0);
    chk(scl_line === 1'b0, "R12", "scl held low while idle", int'(scl_line), 0);
    do_cond(3'd3);
    chk(bad_chg == 0, "R4", "sda changes under high scl", bad_chg, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule